// File: doc/BRIEF.md
# Multi-Bank Program/Erase Sequencer

This block sequences program and erase work on a banked non-volatile array. Decoded requests arrive with a word address. The block maps that address to a bank and a global block number, and it admits at most one running operation at a time. It drives an external operation timer, and the timer reports completion and error back. Erase and program operations can be suspended and resumed. While an erase is suspended, a program may run in any other block, anywhere in the array.

Reads are served in the same cycle they are asked for. A read to an idle bank gets array data. A read to the bank that is running an operation gets the status word instead. A read of the block whose operation is suspended is stalled. The bank and block map comes in two variants, chosen by a parameter: the small-block bank at the bottom of the address space or at the top.

Top module: `flash_pe_sequencer`

## Requirements
- R1: With TOP_PARAM=0, bank = addr[21:18]. Addresses 0x000000 to 0x007FFF hold eight 4K-word blocks, numbered 0 to 7. Every other 32K-word block n (n = addr[21:15]) has the number n+7, so the last block in the array is 134.
- R2: With TOP_PARAM=1, bank = addr[21:18]. 32K-word block n below 0x3F8000 has the number n, covering 0 to 126. The top 32K words hold eight 4K-word blocks, numbered 127 to 134.
- R3: A program or erase request is rejected while another operation is running, while a program is suspended, or (for erase) while an erase is suspended. A rejection pulses cmd_reject high for one cycle, starting the cycle after the request, and the state does not change.
- R4: bank_busy is the one-hot flag of the bank whose operation is running, and is zero otherwise. It is set in the cycle after the request is accepted and cleared in the cycle after op_done. timer_run is high exactly while an operation runs.
- R5: A read to a bank with no running operation, and not aimed at a suspended block, is granted in the same cycle, and rd_data equals array_rdata.
- R6: A read to the bank with a running operation is granted in the same cycle. rd_data then carries the status word in bits 7:0, with zeros above.
- R7: While an erase is suspended, a program to a different block starts. Its completion returns the block to the erase-suspended state, and a resume makes the erase run again.
- R8: A running program or erase is suspended by req_suspend and restarted by req_resume. While suspended, reads of other blocks are granted, but a read of the suspended block raises rd_stall and gets no grant.
- R9: A program request aimed at the erase-suspended block is rejected and sets the program-error bit.
- R10: Status bit positions: bit0 ready (no operation running), bit1 erase suspended, bit2 program suspended, bit3 program error, bit4 erase error, bits 7:5 zero. After reset the status is 0x01.
- R11: op_err together with op_done sets the program-error or erase-error bit, matching the operation that finished. Error bits stay set until req_clear.
- R12: req_suspend, req_resume and op_done have no effect when no operation is in a state they apply to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_prog | input | 1 | Program request at addr |
| req_erase | input | 1 | Block erase request at addr |
| req_suspend | input | 1 | Suspend the running operation |
| req_resume | input | 1 | Resume the suspended operation |
| req_clear | input | 1 | Clear the error bits |
| req_read | input | 1 | Read request at addr |
| addr | input | 22 | Word address shared by all requests |
| array_rdata | input | 16 | Data returned by the array for addr |
| op_done | input | 1 | Operation timer completion |
| op_err | input | 1 | Completion ended in failure |
| timer_run | output | 1 | Operation timer enable |
| bank_busy | output | 16 | One-hot bank with a running operation |
| rd_grant | output | 1 | Read served this cycle |
| rd_stall | output | 1 | Read blocked on a suspended block |
| rd_data | output | 16 | Array data or status word |
| status | output | 8 | Status register |
| cmd_reject | output | 1 | Program or erase request refused |
| cur_bank | output | 4 | Bank decoded from addr |
| cur_block | output | 8 | Global block number decoded from addr |

## Verification
The hardest state to reach is a program running inside an erase suspend, while reads hit three different places: the suspended erase block, the nested program's bank, and an unrelated bank. The directed stimulus starts an erase and suspends it. It then probes the suspended block and a same-bank neighbour, attempts a refused program to the suspended block, and starts a program in another bank. It checks each read class before completing the nested program, then resumes the erase and finishes it with an error.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_PROG_SUSP,
        ST_ERS_SUSP,
        ST_NEST_PROG
    } pe_state_e;

    localparam int STAT_W        = 8;
    localparam int STAT_READY    = 0;
    localparam int STAT_ERS_SUSP = 1;
    localparam int STAT_PRG_SUSP = 2;
    localparam int STAT_PRG_ERR  = 3;
    localparam int STAT_ERS_ERR  = 4;

endpackage

// File: rtl/fseq_block_map.sv
module fseq_block_map #(
    parameter int ADDR_W      = 22,
    parameter int BANK_SPAN_W = 18,
    parameter int MAIN_W      = 15,
    parameter int PARAM_W     = 12,
    parameter bit TOP_PARAM   = 1'b0,
    localparam int HI_W       = ADDR_W - PARAM_W,
    localparam int BANK_W     = ADDR_W - BANK_SPAN_W,
    localparam int SLOT_W     = ADDR_W - MAIN_W,
    localparam int BLK_W      = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HI_W-1:0]   addr_hi,
    output logic [BANK_W-1:0] bank,
    output logic [BLK_W-1:0]  blk
);
    localparam int PBLK_W    = MAIN_W - PARAM_W;
    localparam int NUM_PARAM = 2 ** PBLK_W;
    localparam int NUM_SLOTS = 2 ** SLOT_W;
    localparam int MAX_BLK   = NUM_SLOTS + NUM_PARAM - 2;

    logic [SLOT_W-1:0] slot;
    logic [PBLK_W-1:0] pidx;
    logic              in_param;

    assign slot = addr_hi[HI_W-1:PBLK_W];
    assign pidx = addr_hi[PBLK_W-1:0];
    assign bank = addr_hi[HI_W-1:HI_W-BANK_W];

    generate
        if (TOP_PARAM) begin : g_top
            assign in_param = (slot == {SLOT_W{1'b1}});
            always_comb begin
                if (in_param)
                    blk = BLK_W'(NUM_SLOTS - 1) + BLK_W'(pidx);
                else
                    blk = BLK_W'(slot);
            end
        end else begin : g_bottom
            assign in_param = (slot == '0);
            always_comb begin
                if (in_param)
                    blk = BLK_W'(pidx);
                else
                    blk = BLK_W'(slot) + BLK_W'(NUM_PARAM - 1);
            end
        end
    endgenerate

    // R1 / R2: block number never exceeds the last block of the array
    assert_blk_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        blk <= BLK_W'(MAX_BLK));

    // R2: small blocks live only in the bank at the chosen end
    assert_param_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_param |-> (bank == (TOP_PARAM ? {BANK_W{1'b1}} : {BANK_W{1'b0}})));

endmodule

// File: rtl/fseq_pe_ctrl.sv
module fseq_pe_ctrl
    import flash_seq_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_prog,
    input  logic              req_erase,
    input  logic              req_suspend,
    input  logic              req_resume,
    input  logic              req_clear,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [BLK_W-1:0]  cmd_blk,
    input  logic              op_done,
    input  logic              op_err,
    output logic              running,
    output logic [BANK_W-1:0] run_bank,
    output logic              susp_valid,
    output logic [BLK_W-1:0]  susp_blk,
    output logic [STAT_W-1:0] status,
    output logic              cmd_reject
);
    typedef struct packed {
        pe_state_e         st;
        logic [BANK_W-1:0] op_bank;
        logic [BLK_W-1:0]  op_blk;
        logic [BANK_W-1:0] nest_bank;
        logic              prog_err;
        logic              erase_err;
        logic              reject;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.reject = 1'b0;
        if (req_clear) begin
            ctl_d.prog_err  = 1'b0;
            ctl_d.erase_err = 1'b0;
        end
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_prog) begin
                    ctl_d.st      = ST_PROG;
                    ctl_d.op_bank = cmd_bank;
                    ctl_d.op_blk  = cmd_blk;
                end else if (req_erase) begin
                    ctl_d.st      = ST_ERASE;
                    ctl_d.op_bank = cmd_bank;
                    ctl_d.op_blk  = cmd_blk;
                end
            end
            ST_PROG: begin
                if (op_done) begin
                    ctl_d.st = ST_IDLE;
                    if (op_err) ctl_d.prog_err = 1'b1;
                end else if (req_suspend) begin
                    ctl_d.st = ST_PROG_SUSP;
                end else if (req_prog || req_erase) begin
                    ctl_d.reject = 1'b1;
                end
            end
            ST_ERASE: begin
                if (op_done) begin
                    ctl_d.st = ST_IDLE;
                    if (op_err) ctl_d.erase_err = 1'b1;
                end else if (req_suspend) begin
                    ctl_d.st = ST_ERS_SUSP;
                end else if (req_prog || req_erase) begin
                    ctl_d.reject = 1'b1;
                end
            end
            ST_PROG_SUSP: begin
                if (req_resume)
                    ctl_d.st = ST_PROG;
                else if (req_prog || req_erase)
                    ctl_d.reject = 1'b1;
            end
            ST_ERS_SUSP: begin
                if (req_resume) begin
                    ctl_d.st = ST_ERASE;
                end else if (req_prog) begin
                    if (cmd_blk == ctl_q.op_blk) begin
                        ctl_d.reject   = 1'b1;
                        ctl_d.prog_err = 1'b1;
                    end else begin
                        ctl_d.st        = ST_NEST_PROG;
                        ctl_d.nest_bank = cmd_bank;
                    end
                end else if (req_erase) begin
                    ctl_d.reject = 1'b1;
                end
            end
            ST_NEST_PROG: begin
                if (op_done) begin
                    ctl_d.st = ST_ERS_SUSP;
                    if (op_err) ctl_d.prog_err = 1'b1;
                end else if (req_prog || req_erase) begin
                    ctl_d.reject = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, op_bank: '0, op_blk: '0, nest_bank: '0,
                       prog_err: 1'b0, erase_err: 1'b0, reject: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign running    = (ctl_q.st == ST_PROG) || (ctl_q.st == ST_ERASE) ||
                        (ctl_q.st == ST_NEST_PROG);
    assign run_bank   = (ctl_q.st == ST_NEST_PROG) ? ctl_q.nest_bank : ctl_q.op_bank;
    assign susp_valid = (ctl_q.st == ST_PROG_SUSP) || (ctl_q.st == ST_ERS_SUSP) ||
                        (ctl_q.st == ST_NEST_PROG);
    assign susp_blk   = ctl_q.op_blk;
    assign cmd_reject = ctl_q.reject;

    always_comb begin
        status                = '0;
        status[STAT_READY]    = !running;
        status[STAT_ERS_SUSP] = (ctl_q.st == ST_ERS_SUSP) || (ctl_q.st == ST_NEST_PROG);
        status[STAT_PRG_SUSP] = (ctl_q.st == ST_PROG_SUSP);
        status[STAT_PRG_ERR]  = ctl_q.prog_err;
        status[STAT_ERS_ERR]  = ctl_q.erase_err;
    end

    // R3: request during a running operation is refused, bank unchanged
    assert_reject_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !op_done && !req_suspend && (req_prog || req_erase))
        |=> (cmd_reject && running && $stable(run_bank)));

    // R4: completion of a plain program frees the array
    assert_done_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PROG && op_done) |=> (!running && status[STAT_READY]));

    // R7: nested program completion returns to erase suspend
    assert_nest_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_NEST_PROG && op_done) |=> (status[STAT_ERS_SUSP] && !running));

    // R9: program into the suspended erase block is refused with an error
    assert_same_blk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ERS_SUSP && req_prog && !req_resume && cmd_blk == ctl_q.op_blk)
        |=> (status[STAT_PRG_ERR] && cmd_reject && !running));

    // R11: error bits hold until cleared
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_PRG_ERR] && !req_clear) |=> status[STAT_PRG_ERR]);
    assert_ers_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_ERS_ERR] && !req_clear) |=> status[STAT_ERS_ERR]);

    // R12: suspend and resume while idle leave it idle
    assert_idle_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && !req_prog && !req_erase) |=> (ctl_q.st == ST_IDLE));

endmodule

// File: rtl/fseq_read_path.sv
module fseq_read_path
    import flash_seq_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int BLK_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_read,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [BLK_W-1:0]  rd_blk,
    input  logic              running,
    input  logic [BANK_W-1:0] run_bank,
    input  logic              susp_valid,
    input  logic [BLK_W-1:0]  susp_blk,
    input  logic [STAT_W-1:0] status,
    input  logic [DATA_W-1:0] array_rdata,
    output logic              rd_grant,
    output logic              rd_stall,
    output logic [DATA_W-1:0] rd_data
);
    logic hit_busy;
    logic hit_susp;

    assign hit_busy = running && (rd_bank == run_bank);
    assign hit_susp = susp_valid && (rd_blk == susp_blk);

    always_comb begin
        rd_stall = req_read && hit_susp && !hit_busy;
        rd_grant = req_read && !rd_stall;
        if (hit_busy)
            rd_data = {{(DATA_W - STAT_W){1'b0}}, status};
        else
            rd_data = array_rdata;
    end

    // R8: a stalled read is never granted
    assert_stall_nogrant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> !rd_grant);

    // R5: a read away from the running bank and suspended block passes array data
    assert_free_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_read && !(running && rd_bank == run_bank) && !(susp_valid && rd_blk == susp_blk))
        |-> (rd_grant && rd_data == array_rdata));

    // R6: a read into the running bank is served status
    assert_busy_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_read && running && rd_bank == run_bank)
        |-> (rd_grant && rd_data[STAT_W-1:0] == status));

endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 16,
    parameter int BANK_SPAN_W = 18,
    parameter int MAIN_W      = 15,
    parameter int PARAM_W     = 12,
    parameter bit TOP_PARAM   = 1'b0,
    localparam int BANK_W     = ADDR_W - BANK_SPAN_W,
    localparam int NUM_BANKS  = 2 ** BANK_W,
    localparam int BLK_W      = ADDR_W - MAIN_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_prog,
    input  logic                 req_erase,
    input  logic                 req_suspend,
    input  logic                 req_resume,
    input  logic                 req_clear,
    input  logic                 req_read,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    array_rdata,
    input  logic                 op_done,
    input  logic                 op_err,
    output logic                 timer_run,
    output logic [NUM_BANKS-1:0] bank_busy,
    output logic                 rd_grant,
    output logic                 rd_stall,
    output logic [DATA_W-1:0]    rd_data,
    output logic [STAT_W-1:0]    status,
    output logic                 cmd_reject,
    output logic [BANK_W-1:0]    cur_bank,
    output logic [BLK_W-1:0]     cur_block
);
    logic              running;
    logic [BANK_W-1:0] run_bank;
    logic              susp_valid;
    logic [BLK_W-1:0]  susp_blk;

    fseq_block_map #(
        .ADDR_W      (ADDR_W),
        .BANK_SPAN_W (BANK_SPAN_W),
        .MAIN_W      (MAIN_W),
        .PARAM_W     (PARAM_W),
        .TOP_PARAM   (TOP_PARAM)
    ) i_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_hi (addr[ADDR_W-1:PARAM_W]),
        .bank    (cur_bank),
        .blk     (cur_block)
    );

    fseq_pe_ctrl #(
        .BANK_W (BANK_W),
        .BLK_W  (BLK_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_prog    (req_prog),
        .req_erase   (req_erase),
        .req_suspend (req_suspend),
        .req_resume  (req_resume),
        .req_clear   (req_clear),
        .cmd_bank    (cur_bank),
        .cmd_blk     (cur_block),
        .op_done     (op_done),
        .op_err      (op_err),
        .running     (running),
        .run_bank    (run_bank),
        .susp_valid  (susp_valid),
        .susp_blk    (susp_blk),
        .status      (status),
        .cmd_reject  (cmd_reject)
    );

    fseq_read_path #(
        .BANK_W (BANK_W),
        .BLK_W  (BLK_W),
        .DATA_W (DATA_W)
    ) i_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_read    (req_read),
        .rd_bank     (cur_bank),
        .rd_blk      (cur_block),
        .running     (running),
        .run_bank    (run_bank),
        .susp_valid  (susp_valid),
        .susp_blk    (susp_blk),
        .status      (status),
        .array_rdata (array_rdata),
        .rd_grant    (rd_grant),
        .rd_stall    (rd_stall),
        .rd_data     (rd_data)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_busy
            assign bank_busy[b] = running && (run_bank == BANK_W'(b));
        end
    endgenerate

    assign timer_run = running;

    // R4: at most one bank is ever busy
    assert_one_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_busy));

    // R10: ready flag and busy flags never both claim activity
    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_READY] |-> (bank_busy == '0));

endmodule

// File: tb/test_flash_pe_sequencer.sv
module test_flash_pe_sequencer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_prog = 0, req_erase = 0, req_suspend = 0, req_resume = 0;
    logic        req_clear = 0, req_read = 0, op_done = 0, op_err = 0;
    logic [21:0] addr = '0;
    logic [15:0] array_rdata = 16'hABCD;
    logic        timer_run, rd_grant, rd_stall, cmd_reject;
    logic [15:0] bank_busy, rd_data;
    logic [7:0]  status;
    logic [3:0]  cur_bank;
    logic [7:0]  cur_block;

    logic        h_run, h_grant, h_stall, h_rej;
    logic [15:0] h_busy, h_data;
    logic [7:0]  h_status, h_block;
    logic [3:0]  h_bank;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pe_sequencer i_flash_pe_sequencer (
        .clk(clk), .rst_n(rst_n), .req_prog(req_prog), .req_erase(req_erase),
        .req_suspend(req_suspend), .req_resume(req_resume), .req_clear(req_clear),
        .req_read(req_read), .addr(addr), .array_rdata(array_rdata),
        .op_done(op_done), .op_err(op_err), .timer_run(timer_run),
        .bank_busy(bank_busy), .rd_grant(rd_grant), .rd_stall(rd_stall),
        .rd_data(rd_data), .status(status), .cmd_reject(cmd_reject),
        .cur_bank(cur_bank), .cur_block(cur_block)
    );

    flash_pe_sequencer #(.TOP_PARAM(1'b1)) i_flash_pe_sequencer_hi (
        .clk(clk), .rst_n(rst_n), .req_prog(1'b0), .req_erase(1'b0),
        .req_suspend(1'b0), .req_resume(1'b0), .req_clear(1'b0),
        .req_read(1'b0), .addr(addr), .array_rdata(array_rdata),
        .op_done(1'b0), .op_err(1'b0), .timer_run(h_run),
        .bank_busy(h_busy), .rd_grant(h_grant), .rd_stall(h_stall),
        .rd_data(h_data), .status(h_status), .cmd_reject(h_rej),
        .cur_bank(h_bank), .cur_block(h_block)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // one command cycle; registered outputs are sampled 1 time unit after the edge
    task automatic cmd(input bit p, input bit e, input bit s, input bit r,
                       input bit c, input logic [21:0] a, input bit d, input bit er);
        @(negedge clk);
        req_prog = p; req_erase = e; req_suspend = s; req_resume = r;
        req_clear = c; addr = a; op_done = d; op_err = er;
        @(posedge clk);
        #1;
        req_prog = 0; req_erase = 0; req_suspend = 0; req_resume = 0;
        req_clear = 0; op_done = 0; op_err = 0;
    endtask

    // combinational read, checked before the next edge
    task automatic rd(input string req, input logic [21:0] a, input bit g,
                      input bit st, input logic [15:0] d);
        @(negedge clk);
        req_read = 1; addr = a;
        #1;
        check(req, "rd_grant", rd_grant, g);
        check(req, "rd_stall", rd_stall, st);
        if (g) check(req, "rd_data", rd_data, d);
        req_read = 0;
    endtask

    task automatic t_reset;
        check("R10", "status after reset", status, 8'h01);
        check("R4", "bank_busy after reset", bank_busy, 16'h0);
        check("R4", "timer_run after reset", timer_run, 1'b0);
        check("R3", "cmd_reject after reset", cmd_reject, 1'b0);
    endtask

    task automatic map_lo(input logic [21:0] a, input logic [3:0] b, input logic [7:0] k);
        @(negedge clk); addr = a; #1;
        check("R1", "bottom bank", cur_bank, b);
        check("R1", "bottom block", cur_block, k);
    endtask

    task automatic map_hi(input logic [21:0] a, input logic [3:0] b, input logic [7:0] k);
        @(negedge clk); addr = a; #1;
        check("R2", "top bank", h_bank, b);
        check("R2", "top block", h_block, k);
    endtask

    task automatic t_map;
        map_lo(22'h000000, 4'd0, 8'd0);
        map_lo(22'h001000, 4'd0, 8'd1);
        map_lo(22'h007FFF, 4'd0, 8'd7);
        map_lo(22'h008000, 4'd0, 8'd8);
        map_lo(22'h03FFFF, 4'd0, 8'd14);
        map_lo(22'h040000, 4'd1, 8'd15);
        map_lo(22'h3FFFFF, 4'd15, 8'd134);
        map_hi(22'h000000, 4'd0, 8'd0);
        map_hi(22'h3C0000, 4'd15, 8'd120);
        map_hi(22'h3F7FFF, 4'd15, 8'd126);
        map_hi(22'h3F8000, 4'd15, 8'd127);
        map_hi(22'h3FFFFF, 4'd15, 8'd134);
    endtask

    task automatic t_program;
        cmd(1,0,0,0,0, 22'h040000, 0,0);
        check("R4", "busy after program start", bank_busy, 16'h0002);
        check("R4", "timer_run running", timer_run, 1'b1);
        check("R10", "status running", status, 8'h00);
        rd("R6", 22'h040010, 1, 0, 16'h0000);
        rd("R5", 22'h080000, 1, 0, 16'hABCD);
        cmd(0,1,0,0,0, 22'h0C0000, 0,0);
        check("R3", "reject erase while busy", cmd_reject, 1'b1);
        check("R3", "busy unchanged", bank_busy, 16'h0002);
        cmd(0,0,0,0,0, 22'h0C0000, 0,0);
        check("R3", "reject is one pulse", cmd_reject, 1'b0);
        cmd(0,0,0,0,0, 22'h040000, 1,0);
        check("R4", "busy cleared on done", bank_busy, 16'h0);
        check("R10", "ready after done", status, 8'h01);
    endtask

    task automatic t_errors;
        cmd(1,0,0,0,0, 22'h000000, 0,0);
        cmd(0,0,0,0,0, 22'h000000, 1,1);
        check("R11", "program error set", status, 8'h09);
        cmd(0,1,0,0,0, 22'h300000, 0,0);
        cmd(0,0,0,0,0, 22'h300000, 1,0);
        check("R11", "program error sticky", status, 8'h09);
        cmd(0,0,0,0,1, 22'h300000, 0,0);
        check("R11", "clear errors", status, 8'h01);
    endtask

    task automatic t_erase_suspend;
        cmd(0,1,0,0,0, 22'h100000, 0,0);
        check("R4", "erase busy bank4", bank_busy, 16'h0010);
        cmd(0,0,1,0,0, 22'h100000, 0,0);
        check("R8", "erase suspended status", status, 8'h03);
        check("R8", "no busy bank in suspend", bank_busy, 16'h0);
        rd("R8", 22'h100005, 0, 1, 16'h0);
        rd("R8", 22'h108000, 1, 0, 16'hABCD);
        cmd(0,1,0,0,0, 22'h200000, 0,0);
        check("R3", "erase refused in erase suspend", cmd_reject, 1'b1);
        cmd(1,0,0,0,0, 22'h100100, 0,0);
        check("R9", "reject same block", cmd_reject, 1'b1);
        check("R9", "program error on same block", status, 8'h0B);
        cmd(0,0,0,0,1, 22'h100100, 0,0);
        check("R11", "clear in suspend", status, 8'h03);
        cmd(1,0,0,0,0, 22'h180000, 0,0);
        check("R7", "nested program status", status, 8'h02);
        check("R7", "nested busy bank6", bank_busy, 16'h0040);
        rd("R6", 22'h180004, 1, 0, 16'h0002);
        rd("R8", 22'h100000, 0, 1, 16'h0);
        rd("R5", 22'h140000, 1, 0, 16'hABCD);
        cmd(0,0,0,0,0, 22'h180000, 1,0);
        check("R7", "back to erase suspend", status, 8'h03);
        check("R7", "no busy after nested", bank_busy, 16'h0);
        cmd(0,0,0,1,0, 22'h180000, 0,0);
        check("R7", "erase resumed", status, 8'h00);
        check("R7", "erase bank busy again", bank_busy, 16'h0010);
        cmd(0,0,0,0,0, 22'h180000, 1,1);
        check("R11", "erase error set", status, 8'h11);
        cmd(0,0,0,0,1, 22'h180000, 0,0);
        check("R11", "erase error cleared", status, 8'h01);
    endtask

    task automatic t_program_suspend;
        cmd(1,0,0,0,0, 22'h200000, 0,0);
        cmd(0,0,1,0,0, 22'h200000, 0,0);
        check("R8", "program suspended status", status, 8'h05);
        check("R8", "timer stopped", timer_run, 1'b0);
        rd("R8", 22'h200001, 0, 1, 16'h0);
        array_rdata = 16'h1234;
        rd("R8", 22'h240000, 1, 0, 16'h1234);
        cmd(0,1,0,0,0, 22'h300000, 0,0);
        check("R3", "erase refused in program suspend", cmd_reject, 1'b1);
        check("R3", "state held in program suspend", status, 8'h05);
        cmd(0,0,0,1,0, 22'h200000, 0,0);
        check("R8", "program resumed", status, 8'h00);
        check("R8", "busy bank8", bank_busy, 16'h0100);
        cmd(0,0,0,0,0, 22'h200000, 1,0);
        check("R8", "program done", status, 8'h01);
    endtask

    task automatic t_ignored;
        cmd(0,0,1,0,0, 22'h000000, 0,0);
        check("R12", "suspend idle", status, 8'h01);
        cmd(0,0,0,1,0, 22'h000000, 0,0);
        check("R12", "resume idle", status, 8'h01);
        cmd(0,0,0,0,0, 22'h000000, 1,1);
        check("R12", "done idle", status, 8'h01);
        check("R12", "busy idle", bank_busy, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_map();
        t_program();
        t_errors();
        t_erase_suspend();
        t_program_suspend();
        t_ignored();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule